// File: doc/BRIEF.md
# Triangular Carrier Counter with Sub-Tick Unary Edge Encoder

This block is the timing core of a center-aligned pulse generator that places edges more finely than its own clock. A single up/down counter runs at the slow tick clock. It forms a triangular carrier that climbs from zero to a peak value and then descends back to one. Every output channel uses the same counter. For each channel pair, two encoders turn compare values into one 8-bit word per tick. One encoder drives the positive output and the other the complementary negative output. Each bit of the word gives the output level in one of eight equal slots of the tick. A downstream 8:1 serializer shifts the word out, bit 0 first.

The tick index of a compare value is held in its upper bits, and its lower three bits give a slot inside that tick. In any tick other than the matching one, the word is flat: all ones or all zeros. In the matching tick, the lower three bits set where the edge falls inside the word. Each output has two compare values, one used during the rising half of the carrier and one during the falling half. The values themselves, including any dead-time offset, come from upstream logic. The negative output is encoded as the bitwise inverse of the positive rule, applied to its own compare values.

The counter is a two-state machine. In state TRI_RISE it counts up. The transition PEAK_TURN happens when the counter steps from PERIOD-1 to PERIOD and enters TRI_FALL. In state TRI_FALL it counts down. The transition VALLEY_TURN happens when the counter steps from 1 to 0 and returns to TRI_RISE. The parameter PERIOD must be a multiple of 16.

Top module: `tri_unary_pwm`

## Requirements
- R1: While `rst` is high, at the next clock edge `tick_cnt` becomes 0, `rising` becomes 1, and every byte of `pos_word` and `neg_word` becomes 8'h00.
- R2: In the rising half, `tick_cnt` increases by exactly one per clock, from 0 up to PERIOD.
- R3: In the falling half, `tick_cnt` decreases by exactly one per clock, from PERIOD down to 1. The value after 1 is 0, so one carrier cycle lasts 2*PERIOD clocks.
- R4: `rising` is 1 in the ticks where the counter shows 0 to PERIOD-1 and 0 in the ticks where it shows PERIOD down to 1. The flag changes in the same cycle that the counter reaches PERIOD, and again in the cycle it reaches 0.
- R5: In a rising tick with counter value c, bit s of the positive word is 1 exactly when 8*c+s >= the rising compare value. So the word is 8'h00 below the matching tick and 8'hFF above it. In the matching tick with low bits k, the word is 8'hFF<<k.
- R6: In a falling tick with counter value c, bit s of the positive word is 1 exactly when 8*c+(7-s) >= the falling compare value. In the matching tick with low bits k, the word is 8'hFF>>k.
- R7: The negative word follows the R5/R6 rule applied to the negative output's own rising and falling compare values, with every bit inverted.
- R8: A word reflects the counter value, the `rising` flag and the compare inputs present one clock before it appears.
- R9: Pair i uses compare bits [i*CMP_W +: CMP_W] of each compare port and drives word bits [i*8 +: 8]. Each pair is affected only by its own fields. CMP_W is the counter width plus 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_rise_cmp | input | N_PAIRS*CMP_W | Positive-output compare values used during the rising half |
| pos_fall_cmp | input | N_PAIRS*CMP_W | Positive-output compare values used during the falling half |
| neg_rise_cmp | input | N_PAIRS*CMP_W | Negative-output compare values used during the rising half |
| neg_fall_cmp | input | N_PAIRS*CMP_W | Negative-output compare values used during the falling half |
| tick_cnt | output | CNT_W | Carrier counter value |
| rising | output | 1 | 1 while the carrier is in its rising half |
| pos_word | output | N_PAIRS*8 | Slot words for the positive outputs, bit 0 earliest |
| neg_word | output | N_PAIRS*8 | Slot words for the negative outputs, bit 0 earliest |

## Verification
`tick_cnt` and `rising` come from a register. They are compared every cycle against a bench model that advances one step per clock from the release of reset. The words come one clock after the counter state and compare inputs they depend on. So at each falling edge the bench computes the expected words from the model's current counter and the compare values it is about to drive. It checks those words at the next falling edge. Compare values are drawn close to the current tick so that matching ticks, including the edge cases k=0 and k=7, occur often. They are mixed with fully random values that produce flat words.

// File: rtl/tri_unary_pkg.sv
package tri_unary_pkg;

    typedef enum logic {
        TRI_RISE = 1'b0,
        TRI_FALL = 1'b1
    } tri_state_e;

    localparam int SLOTS     = 8;
    localparam int SLOT_BITS = 3;

endpackage

// File: rtl/tri_carrier_counter.sv
module tri_carrier_counter
    import tri_unary_pkg::*;
#(
    parameter int PERIOD = 64,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rising_o
);

    localparam logic [CNT_W-1:0] PEAK     = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] PRE_PEAK = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    tri_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRI_RISE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRI_RISE: begin
                cnt_d = cnt_q + ONE;
                if (cnt_q == PRE_PEAK) state_d = TRI_FALL;   // PEAK_TURN
            end
            TRI_FALL: begin
                cnt_d = cnt_q - ONE;
                if (cnt_q == ONE) state_d = TRI_RISE;        // VALLEY_TURN
            end
            default: begin
                state_d = TRI_RISE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt_o    = cnt_q;
        rising_o = (state_q == TRI_RISE);
    end

    assert_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= PEAK);

    assert_rise_step_R2: assert property (@(posedge clk) disable iff (rst)
        rising_o |=> (cnt_q == $past(cnt_q) + ONE));

    assert_fall_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!rising_o && cnt_q != ONE) |=> (!rising_o && cnt_q == $past(cnt_q) - ONE));

    assert_valley_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!rising_o && cnt_q == ONE) |=> (rising_o && cnt_q == '0));

    assert_peak_turn_R4: assert property (@(posedge clk) disable iff (rst)
        (rising_o && cnt_q == PRE_PEAK) |=> (!rising_o && cnt_q == PEAK));

endmodule

// File: rtl/tri_slot_encoder.sv
module tri_slot_encoder
    import tri_unary_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter bit INVERT = 1'b0,
    parameter int CMP_W  = CNT_W + SLOT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rising_i,
    input  logic [CMP_W-1:0] cmp_rise_i,
    input  logic [CMP_W-1:0] cmp_fall_i,
    output logic [SLOTS-1:0] word_o
);

    logic [CMP_W-1:0]     cmp_sel;
    logic [CNT_W-1:0]     cmp_tick;
    logic [SLOT_BITS-1:0] cmp_slot;
    logic [SLOTS-1:0]     raw_word;
    logic [SLOTS-1:0]     word_d;
    logic [SLOTS-1:0]     word_q;

    always_comb begin
        cmp_sel  = rising_i ? cmp_rise_i : cmp_fall_i;
        cmp_tick = cmp_sel[CMP_W-1:SLOT_BITS];
        cmp_slot = cmp_sel[SLOT_BITS-1:0];
        if (cmp_tick == cnt_i)
            raw_word = rising_i ? (8'hFF << cmp_slot) : (8'hFF >> cmp_slot);
        else if (cnt_i > cmp_tick)
            raw_word = 8'hFF;
        else
            raw_word = 8'h00;
    end

    generate
        if (INVERT) begin : g_neg
            assign word_d = ~raw_word;
        end else begin : g_pos
            assign word_d = raw_word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word_o = word_q;

    assert_flat_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (cmp_tick != cnt_i) |=> (word_o == 8'h00 || word_o == 8'hFF));

    assert_below_level_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_i < cmp_tick) |=> (word_o == (INVERT ? 8'hFF : 8'h00)));

endmodule

// File: rtl/tri_unary_pwm.sv
module tri_unary_pwm
    import tri_unary_pkg::*;
#(
    parameter int PERIOD  = 64,
    parameter int N_PAIRS = 2,
    parameter int CNT_W   = $clog2(PERIOD + 1),
    parameter int CMP_W   = CNT_W + SLOT_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PAIRS*CMP_W-1:0] pos_rise_cmp,
    input  logic [N_PAIRS*CMP_W-1:0] pos_fall_cmp,
    input  logic [N_PAIRS*CMP_W-1:0] neg_rise_cmp,
    input  logic [N_PAIRS*CMP_W-1:0] neg_fall_cmp,
    output logic [CNT_W-1:0]         tick_cnt,
    output logic                     rising,
    output logic [N_PAIRS*SLOTS-1:0] pos_word,
    output logic [N_PAIRS*SLOTS-1:0] neg_word
);

    logic [CNT_W-1:0] cnt;
    logic             rise;

    tri_carrier_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .cnt_o    (cnt),
        .rising_o (rise)
    );

    assign tick_cnt = cnt;
    assign rising   = rise;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic [SLOTS-1:0] pw, nw;

        tri_slot_encoder #(.CNT_W(CNT_W), .INVERT(1'b0), .CMP_W(CMP_W)) u_pos (
            .clk        (clk),
            .rst        (rst),
            .cnt_i      (cnt),
            .rising_i   (rise),
            .cmp_rise_i (pos_rise_cmp[p*CMP_W +: CMP_W]),
            .cmp_fall_i (pos_fall_cmp[p*CMP_W +: CMP_W]),
            .word_o     (pw)
        );

        tri_slot_encoder #(.CNT_W(CNT_W), .INVERT(1'b1), .CMP_W(CMP_W)) u_neg (
            .clk        (clk),
            .rst        (rst),
            .cnt_i      (cnt),
            .rising_i   (rise),
            .cmp_rise_i (neg_rise_cmp[p*CMP_W +: CMP_W]),
            .cmp_fall_i (neg_fall_cmp[p*CMP_W +: CMP_W]),
            .word_o     (nw)
        );

        assign pos_word[p*SLOTS +: SLOTS] = pw;
        assign neg_word[p*SLOTS +: SLOTS] = nw;

        assert_complement_R7: assert property (@(posedge clk) disable iff (rst)
            (pos_rise_cmp[p*CMP_W +: CMP_W] == neg_rise_cmp[p*CMP_W +: CMP_W] &&
             pos_fall_cmp[p*CMP_W +: CMP_W] == neg_fall_cmp[p*CMP_W +: CMP_W])
            |=> (nw == ~pw));
    end

endmodule

// File: tb/tri_unary_pwm_test.sv
module tri_unary_pwm_test;

    localparam int PERIOD  = 64;
    localparam int N_PAIRS = 2;
    localparam int CNT_W   = $clog2(PERIOD + 1);
    localparam int CMP_W   = CNT_W + 3;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [N_PAIRS*CMP_W-1:0] pos_rise_cmp = '0;
    logic [N_PAIRS*CMP_W-1:0] pos_fall_cmp = '0;
    logic [N_PAIRS*CMP_W-1:0] neg_rise_cmp = '0;
    logic [N_PAIRS*CMP_W-1:0] neg_fall_cmp = '0;
    logic [CNT_W-1:0]         tick_cnt;
    logic                     rising;
    logic [N_PAIRS*8-1:0]     pos_word;
    logic [N_PAIRS*8-1:0]     neg_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tri_unary_pwm #(.PERIOD(PERIOD), .N_PAIRS(N_PAIRS)) uut (
        .clk(clk), .rst(rst),
        .pos_rise_cmp(pos_rise_cmp), .pos_fall_cmp(pos_fall_cmp),
        .neg_rise_cmp(neg_rise_cmp), .neg_fall_cmp(neg_fall_cmp),
        .tick_cnt(tick_cnt), .rising(rising),
        .pos_word(pos_word), .neg_word(neg_word)
    );

    // expected slot word from the slot-threshold rules of R5/R6/R7
    function automatic logic [7:0] slot_word(int c, bit rise, int cmp, bit inv);
        logic [7:0] w;
        for (int s = 0; s < 8; s++) begin
            if (rise) w[s] = (8 * c + s) >= cmp;
            else      w[s] = (8 * c + (7 - s)) >= cmp;
        end
        return inv ? ~w : w;
    endfunction

    function automatic int pick_cmp(int c, int mode);
        int hi;
        int lo;
        case (mode)
            0: begin
                hi = c + int'($urandom % 3) - 1;
                if (hi < 0) hi = 0;
                if (hi > PERIOD) hi = PERIOD;
                lo = int'($urandom % 8);
            end
            1: begin hi = c; lo = 0; end
            2: begin hi = c; lo = 7; end
            default: begin
                hi = int'($urandom % (PERIOD + 1));
                lo = int'($urandom % 8);
            end
        endcase
        return hi * 8 + lo;
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    int         m_cnt  = 0;
    bit         m_rise = 1'b1;
    logic [7:0] e_pos [N_PAIRS];
    logic [7:0] e_neg [N_PAIRS];

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < N_PAIRS; p++) begin
            e_pos[p] = 8'h00;
            e_neg[p] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cnt", int'(tick_cnt), 0);
        check("R1 rising", int'(rising), 1);
        check("R1 pos_word", int'(pos_word), 0);
        check("R1 neg_word", int'(neg_word), 0);

        for (int cyc = 0; cyc < 1600; cyc++) begin
            int mode;
            mode = (cyc / 16) % 4;
            if (cyc != 0) begin
                string t;
                check("R2 R3 cnt", int'(tick_cnt), m_cnt);
                check("R4 rising", int'(rising), int'(m_rise));
                for (int p = 0; p < N_PAIRS; p++) begin
                    t = (p > 0) ? " R9" : "";
                    check({"R5 R6 R8 pos", t}, int'(pos_word[p*8 +: 8]), int'(e_pos[p]));
                    check({"R7 R8 neg", t}, int'(neg_word[p*8 +: 8]), int'(e_neg[p]));
                end
            end
            rst = 1'b0;
            // drive new compares; expected words use the current tick (R8)
            for (int p = 0; p < N_PAIRS; p++) begin
                int pr, pf, nr, nf;
                pr = pick_cmp(m_cnt, mode);
                pf = pick_cmp(m_cnt, mode);
                nr = pick_cmp(m_cnt, (mode + p) % 4);
                nf = pick_cmp(m_cnt, (mode + p) % 4);
                pos_rise_cmp[p*CMP_W +: CMP_W] = CMP_W'(pr);
                pos_fall_cmp[p*CMP_W +: CMP_W] = CMP_W'(pf);
                neg_rise_cmp[p*CMP_W +: CMP_W] = CMP_W'(nr);
                neg_fall_cmp[p*CMP_W +: CMP_W] = CMP_W'(nf);
                e_pos[p] = slot_word(m_cnt, m_rise, m_rise ? pr : pf, 1'b0);
                e_neg[p] = slot_word(m_cnt, m_rise, m_rise ? nr : nf, 1'b1);
            end
            // carrier model (R2 R3 R4)
            if (m_rise) begin
                if (m_cnt == PERIOD - 1) begin m_cnt = PERIOD; m_rise = 1'b0; end
                else m_cnt++;
            end else begin
                if (m_cnt == 1) begin m_cnt = 0; m_rise = 1'b1; end
                else m_cnt--;
            end
            @(negedge clk);
        end

        // R1: reset reapplied mid-run returns to the reset state
        rst = 1'b1;
        @(negedge clk);
        check("R1 cnt after rerun", int'(tick_cnt), 0);
        check("R1 rising after rerun", int'(rising), 1);
        check("R1 words after rerun", int'({pos_word, neg_word}), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule